// File: doc/BRIEF.md
# Host Bridge Address Decoder

The decoder takes one 32-bit CPU request at a time and steers it to exactly one of five downstream targets: configuration space, I/O space, PCI memory space, the interrupt-acknowledge port and the boot ROM window. It also rewrites the CPU address into the selected target's local address. For configuration accesses, the one-hot device-select lines carried in the address are turned into a binary device number. For the lowest 8 MB of I/O space, a run-time mode input chooses either a plain 64 KB contiguous layout or a sparse layout. The sparse layout packs the byte-offset bits together with page-number bits.

A small state machine sequences each access. In **IDLE** the block raises `req_ready`, and an accepted request takes the transition *accept* to **ISSUE**. In **ISSUE** the translated access is presented to the chosen target for one cycle, with `tgt_valid` and a one-hot `tgt_sel`, and read data is captured. If no window matches, a one-cycle decode-error pulse is raised instead. The transition *issue_done* always leads to **RESP**. In **RESP** the response is held until `rsp_ready` is seen, and the transition *resp_taken* returns the block to **IDLE**. The I/O mode and all request fields are sampled at acceptance.

Top module: `hb_addr_decoder`

## Requirements
- R1: A request is accepted only while `req_ready` is high. Exactly one cycle later `tgt_valid` is high for exactly one cycle, with a one-hot `tgt_sel` (bit0 configuration, bit1 I/O, bit2 memory, bit3 interrupt-acknowledge, bit4 boot ROM). `tgt_sel` is zero whenever `tgt_valid` is low.
- R2: Addresses 0x80800000 to 0x80BFFFFF select configuration space. The local address keeps address bits [10:0] and places at bits 11 and up the index (0 to 10) of the lowest set bit among address bits 11 to 21, or 11 when none of those bits is set.
- R3: Addresses 0x80C00000 to 0xBF7FFFFF select I/O space with local address = address − 0x80000000. The configuration window wins over this overlapping range.
- R4: With `io_sparse` = 0, addresses 0x80000000 to 0x807FFFFF select I/O space with local address = bits [15:0] of (address − 0x80000000).
- R5: With `io_sparse` = 1, the same 8 MB range selects I/O space with local address = offset[4:0] OR (offset[22:12] shifted left by 5), where offset = address − 0x80000000. The mode is sampled at acceptance and may change between requests.
- R6: Addresses 0xC0000000 to 0xFEFFFFFF select memory space with local address = address − 0xC0000000.
- R7: Addresses 0xFFF00000 to 0xFFFFFFFF select the boot ROM with local address = address − 0xFFF00000.
- R8: A one-byte access (`req_size` = 1) at 0xBFFFFFF0 selects interrupt-acknowledge with local address 0. A read returns {24'b0, `iack_vector`}. A write is dropped: no `tgt_valid`, no error, and the response data is 0.
- R9: Any other address, including a non-byte access at 0xBFFFFFF0, raises `dec_err` for exactly one cycle, in the cycle after acceptance, with no `tgt_valid`. A read returns 0xFFFFFFFF.
- R10: `rsp_valid` rises two cycles after acceptance and stays high with stable `rsp_rdata` until `rsp_ready` is sampled high. Read data is the `tgt_rdata` present during the issue cycle, write responses return 0, and `req_ready` stays low from acceptance until the response is taken.
- R11: During the issue cycle `tgt_write`, `tgt_size` and `tgt_wdata` equal the accepted request's write flag, size and write data.
- R12: After reset `req_ready` is 1 and `rsp_valid`, `tgt_valid` and `dec_err` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_sparse | input | 1 | I/O layout for the low 8 MB: 0 contiguous, 1 sparse |
| req_valid | input | 1 | CPU request present |
| req_ready | output | 1 | Decoder can accept a request |
| req_addr | input | 32 | CPU byte address |
| req_write | input | 1 | 1 for write, 0 for read |
| req_size | input | 3 | Access size in bytes (1, 2 or 4) |
| req_wdata | input | 32 | Write data, little-endian lanes |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | CPU takes the response |
| rsp_rdata | output | 32 | Read data, all ones on decode error |
| dec_err | output | 1 | One-cycle unmapped-address pulse |
| tgt_sel | output | 5 | One-hot target select |
| tgt_valid | output | 1 | Access strobe to the selected target |
| tgt_addr | output | 32 | Translated local address |
| tgt_write | output | 1 | Write flag to the target |
| tgt_size | output | 3 | Access size to the target |
| tgt_wdata | output | 32 | Write data to the target |
| tgt_rdata | input | 32 | Read data from the selected target during issue |
| iack_vector | input | 8 | Pending interrupt vector for interrupt-acknowledge reads |

## Verification
The bench builds the decoder with its default parameters: eleven device-select lanes starting at bit 11, a 5-bit low field with page bits 12 to 22 for the sparse layout, and a 16-bit contiguous layout. With these values it is practical to sweep every device-select lane, the no-lane case and a multi-lane case, and to visit both I/O layouts with the mode flipped between back-to-back requests. It also reaches the first and last byte of every window and the unmapped gaps next to them, including the neighbours of the interrupt-acknowledge address.

// File: rtl/hbd_pkg.sv
package hbd_pkg;

    typedef enum logic [2:0] {
        TGT_CFG  = 3'd0,
        TGT_IO   = 3'd1,
        TGT_MEM  = 3'd2,
        TGT_IACK = 3'd3,
        TGT_ROM  = 3'd4,
        TGT_NONE = 3'd5
    } hbd_tgt_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_RESP  = 2'd2
    } hbd_state_e;

    localparam int unsigned NUM_TGT = 5;

endpackage

// File: rtl/hbd_window_match.sv
module hbd_window_match
    import hbd_pkg::*;
#(
    parameter int unsigned  AW          = 32,
    parameter int unsigned  SW          = 3,
    parameter logic [31:0]  CFG_BASE    = 32'h8080_0000,
    parameter logic [31:0]  CFG_SIZE    = 32'h0040_0000,
    parameter logic [31:0]  IO_BASE     = 32'h8000_0000,
    parameter logic [31:0]  IO_SIZE     = 32'h3F80_0000,
    parameter logic [31:0]  SPARSE_SIZE = 32'h0080_0000,
    parameter logic [31:0]  IACK_ADDR   = 32'hBFFF_FFF0,
    parameter logic [31:0]  MEM_BASE    = 32'hC000_0000,
    parameter logic [31:0]  MEM_SIZE    = 32'h3F00_0000,
    parameter logic [31:0]  ROM_BASE    = 32'hFFF0_0000
) (
    input  logic [AW-1:0] addr,
    input  logic [SW-1:0] size,
    output hbd_tgt_e      tgt,
    output logic          low_io
);
    localparam logic [AW:0] CFG_END = {1'b0, CFG_BASE} + {1'b0, CFG_SIZE};
    localparam logic [AW:0] IO_END  = {1'b0, IO_BASE}  + {1'b0, IO_SIZE};
    localparam logic [AW:0] SP_END  = {1'b0, IO_BASE}  + {1'b0, SPARSE_SIZE};
    localparam logic [AW:0] MEM_END = {1'b0, MEM_BASE} + {1'b0, MEM_SIZE};

    logic [AW:0] a;
    logic        cfg_hit, io_hit, iack_hit, mem_hit, rom_hit;

    assign a        = {1'b0, addr};
    assign cfg_hit  = (addr >= CFG_BASE) && (a < CFG_END);
    assign io_hit   = (addr >= IO_BASE)  && (a < IO_END);
    assign low_io   = (addr >= IO_BASE)  && (a < SP_END);
    assign iack_hit = (addr == IACK_ADDR) && (size == SW'(1));
    assign mem_hit  = (addr >= MEM_BASE) && (a < MEM_END);
    assign rom_hit  = (addr >= ROM_BASE);

    always_comb begin
        if (cfg_hit)       tgt = TGT_CFG;
        else if (io_hit)   tgt = TGT_IO;
        else if (iack_hit) tgt = TGT_IACK;
        else if (mem_hit)  tgt = TGT_MEM;
        else if (rom_hit)  tgt = TGT_ROM;
        else               tgt = TGT_NONE;
    end
endmodule

// File: rtl/hbd_devnum_enc.sv
module hbd_devnum_enc #(
    parameter int unsigned LANES = 11,
    parameter int unsigned DEV_W = $clog2(LANES + 1)
) (
    input  logic [LANES-1:0] lanes,
    output logic [DEV_W-1:0] devnum
);
    always_comb begin
        devnum = DEV_W'(LANES);
        for (int i = LANES - 1; i >= 0; i--) begin
            if (lanes[i]) devnum = DEV_W'(i);
        end
    end
endmodule

// File: rtl/hbd_addr_xlate.sv
module hbd_addr_xlate
    import hbd_pkg::*;
#(
    parameter int unsigned AW          = 32,
    parameter int unsigned DEV_LSB     = 11,
    parameter int unsigned DEV_LANES   = 11,
    parameter int unsigned CONTIG_W    = 16,
    parameter int unsigned SP_LOW_W    = 5,
    parameter int unsigned SP_PAGE_LSB = 12,
    parameter int unsigned SP_PAGE_MSB = 22,
    parameter logic [31:0] IO_BASE     = 32'h8000_0000,
    parameter logic [31:0] MEM_BASE    = 32'hC000_0000,
    parameter logic [31:0] ROM_BASE    = 32'hFFF0_0000
) (
    input  logic [AW-1:0] addr,
    input  hbd_tgt_e      tgt,
    input  logic          low_io,
    input  logic          sparse,
    output logic [AW-1:0] local_addr
);
    localparam int unsigned DEV_W = $clog2(DEV_LANES + 1);

    logic [DEV_W-1:0] devnum;
    logic [AW-1:0]    io_off;
    logic [AW-1:0]    io_packed;

    hbd_devnum_enc #(.LANES(DEV_LANES), .DEV_W(DEV_W)) u_enc (
        .lanes  (addr[DEV_LSB +: DEV_LANES]),
        .devnum (devnum)
    );

    assign io_off    = addr - IO_BASE;
    assign io_packed = AW'(io_off[SP_LOW_W-1:0])
                     | (AW'(io_off[SP_PAGE_MSB:SP_PAGE_LSB]) << SP_LOW_W);

    always_comb begin
        unique case (tgt)
            TGT_CFG:  local_addr = (AW'(devnum) << DEV_LSB) | AW'(addr[DEV_LSB-1:0]);
            TGT_IO: begin
                if (!low_io)     local_addr = io_off;
                else if (sparse) local_addr = io_packed;
                else             local_addr = AW'(io_off[CONTIG_W-1:0]);
            end
            TGT_MEM:  local_addr = addr - MEM_BASE;
            TGT_ROM:  local_addr = addr - ROM_BASE;
            TGT_IACK: local_addr = '0;
            default:  local_addr = addr;
        endcase
    end
endmodule

// File: rtl/hb_addr_decoder.sv
module hb_addr_decoder
    import hbd_pkg::*;
#(
    parameter int unsigned AW          = 32,
    parameter int unsigned DW          = 32,
    parameter int unsigned SW          = 3,
    parameter int unsigned VW          = 8,
    parameter int unsigned DEV_LSB     = 11,
    parameter int unsigned DEV_LANES   = 11,
    parameter int unsigned CONTIG_W    = 16,
    parameter int unsigned SP_LOW_W    = 5,
    parameter int unsigned SP_PAGE_LSB = 12,
    parameter int unsigned SP_PAGE_MSB = 22
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                io_sparse,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [AW-1:0]       req_addr,
    input  logic                req_write,
    input  logic [SW-1:0]       req_size,
    input  logic [DW-1:0]       req_wdata,
    output logic                rsp_valid,
    input  logic                rsp_ready,
    output logic [DW-1:0]       rsp_rdata,
    output logic                dec_err,
    output logic [NUM_TGT-1:0]  tgt_sel,
    output logic                tgt_valid,
    output logic [AW-1:0]       tgt_addr,
    output logic                tgt_write,
    output logic [SW-1:0]       tgt_size,
    output logic [DW-1:0]       tgt_wdata,
    input  logic [DW-1:0]       tgt_rdata,
    input  logic [VW-1:0]       iack_vector
);
    hbd_state_e    state, state_nxt;
    hbd_tgt_e      dec_tgt, cur_tgt;
    logic          dec_low_io;
    logic [AW-1:0] dec_addr;
    logic [DW-1:0] rdata_q;
    logic          accept, drop_write;

    hbd_window_match #(.AW(AW), .SW(SW)) u_match (
        .addr   (req_addr),
        .size   (req_size),
        .tgt    (dec_tgt),
        .low_io (dec_low_io)
    );

    hbd_addr_xlate #(
        .AW(AW), .DEV_LSB(DEV_LSB), .DEV_LANES(DEV_LANES), .CONTIG_W(CONTIG_W),
        .SP_LOW_W(SP_LOW_W), .SP_PAGE_LSB(SP_PAGE_LSB), .SP_PAGE_MSB(SP_PAGE_MSB)
    ) u_xlate (
        .addr       (req_addr),
        .tgt        (dec_tgt),
        .low_io     (dec_low_io),
        .sparse     (io_sparse),
        .local_addr (dec_addr)
    );

    assign accept     = req_valid && (state == ST_IDLE);
    assign drop_write = (cur_tgt == TGT_IACK) && tgt_write;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // transitions: accept, issue_done, resp_taken
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (accept)    state_nxt = ST_ISSUE;
            ST_ISSUE:                state_nxt = ST_RESP;
            ST_RESP:  if (rsp_ready) state_nxt = ST_IDLE;
            default:                 state_nxt = ST_IDLE;
        endcase
    end

    // request capture and response data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_tgt   <= TGT_NONE;
            tgt_addr  <= '0;
            tgt_write <= 1'b0;
            tgt_size  <= '0;
            tgt_wdata <= '0;
            rdata_q   <= '0;
        end else begin
            if (accept) begin
                cur_tgt   <= dec_tgt;
                tgt_addr  <= dec_addr;
                tgt_write <= req_write;
                tgt_size  <= req_size;
                tgt_wdata <= req_wdata;
            end
            if (state == ST_ISSUE) begin
                if (tgt_write)                rdata_q <= '0;
                else if (cur_tgt == TGT_NONE) rdata_q <= '1;
                else if (cur_tgt == TGT_IACK) rdata_q <= DW'(iack_vector);
                else                          rdata_q <= tgt_rdata;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        tgt_valid = 1'b0;
        dec_err   = 1'b0;
        rsp_rdata = rdata_q;
        unique case (state)
            ST_IDLE:  req_ready = 1'b1;
            ST_ISSUE: begin
                dec_err   = (cur_tgt == TGT_NONE);
                tgt_valid = (cur_tgt != TGT_NONE) && !drop_write;
            end
            ST_RESP:  rsp_valid = 1'b1;
            default:  ;
        endcase
        tgt_sel = tgt_valid ? (NUM_TGT'(1) << cur_tgt) : '0;
    end
endmodule

// File: rtl/hbd_checker.sv
module hbd_checker #(
    parameter int unsigned DW      = 32,
    parameter int unsigned NUM_SEL = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic               rsp_valid,
    input logic               rsp_ready,
    input logic [DW-1:0]      rsp_rdata,
    input logic               dec_err,
    input logic [NUM_SEL-1:0] tgt_sel,
    input logic               tgt_valid
);
    // R1
    sel_onehot0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tgt_sel));

    // R1
    sel_with_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_valid |-> ($countones(tgt_sel) == 1));

    // R1
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_valid |=> !tgt_valid);

    // R9
    err_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_err |-> (!tgt_valid && tgt_sel == '0));

    // R9
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_err |=> !dec_err);

    // R10
    strobe_then_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_valid || dec_err) |=> rsp_valid);

    // R10
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

    // R10
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R10
    no_accept_in_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);
endmodule

bind hb_addr_decoder hbd_checker #(.DW(DW), .NUM_SEL(hbd_pkg::NUM_TGT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_rdata (rsp_rdata),
    .dec_err   (dec_err),
    .tgt_sel   (tgt_sel),
    .tgt_valid (tgt_valid)
);

// File: tb/hb_addr_decoder_test.sv
module hb_addr_decoder_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_sparse = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [2:0]  req_size = 3'd4;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [31:0] rsp_rdata;
    logic        dec_err;
    logic [4:0]  tgt_sel;
    logic        tgt_valid;
    logic [31:0] tgt_addr;
    logic        tgt_write;
    logic [2:0]  tgt_size;
    logic [31:0] tgt_wdata;
    logic [31:0] tgt_rdata;
    logic [7:0]  iack_vector = 8'h3C;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // simple target model: read data derived from the local address
    assign tgt_rdata = tgt_addr ^ 32'h5A5A_0F0F;

    hb_addr_decoder uut (.*);

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // independent reference of the address map
    task automatic model(input logic [31:0] a, input bit wr, input logic [2:0] sz,
                         input bit sp, output logic [4:0] sel,
                         output logic [31:0] la, output string tag);
        longint unsigned off;
        int dev;
        sel = 5'b0; la = 32'h0; tag = "R9";
        if (a >= 32'h8080_0000 && a <= 32'h80BF_FFFF) begin
            dev = 11;
            for (int i = 10; i >= 0; i--) if (a[11+i]) dev = i;
            sel = 5'b00001; la = dev * 2048 + (a % 2048); tag = "R2";
        end else if (a >= 32'h8000_0000 && a <= 32'hBF7F_FFFF) begin
            off = a - 32'h8000_0000;
            sel = 5'b00010;
            if (off >= 64'h80_0000) begin la = off; tag = "R3"; end
            else if (sp) begin la = (off % 32) + ((off / 4096) % 2048) * 32; tag = "R5"; end
            else begin la = off % 65536; tag = "R4"; end
        end else if (a == 32'hBFFF_FFF0 && sz == 3'd1) begin
            sel = wr ? 5'b0 : 5'b01000; la = 0; tag = "R8";
        end else if (a >= 32'hC000_0000 && a <= 32'hFEFF_FFFF) begin
            sel = 5'b00100; la = a - 32'hC000_0000; tag = "R6";
        end else if (a >= 32'hFFF0_0000) begin
            sel = 5'b10000; la = a - 32'hFFF0_0000; tag = "R7";
        end
    endtask

    task automatic run(input logic [31:0] a, input bit wr, input logic [2:0] sz,
                       input logic [31:0] wd, input bit sp, input int hold);
        logic [4:0]  esel;
        logic [31:0] ela, erd;
        string       tag;
        bit          eerr;
        model(a, wr, sz, sp, esel, ela, tag);
        eerr = (tag == "R9");
        if (wr)        erd = 32'h0;
        else if (eerr) erd = 32'hFFFF_FFFF;
        else if (esel == 5'b01000) erd = {24'h0, iack_vector};
        else           erd = ela ^ 32'h5A5A_0F0F;

        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = wr; req_size = sz;
        req_wdata = wd; io_sparse = sp;
        check(req_ready == 1'b1, "R1", "req_ready before accept", {31'b0, req_ready}, 32'h1);
        @(negedge clk);
        req_valid = 1'b0; io_sparse = ~sp;
        check(tgt_sel == esel, tag, "tgt_sel", {27'b0, tgt_sel}, {27'b0, esel});
        check(tgt_valid == (esel != 0), "R1", "tgt_valid", {31'b0, tgt_valid}, {31'b0, esel != 0});
        check(dec_err == eerr, "R9", "dec_err in issue", {31'b0, dec_err}, {31'b0, eerr});
        if (esel != 0) begin
            check(tgt_addr == ela, tag, "tgt_addr", tgt_addr, ela);
            check(tgt_write == wr && tgt_size == sz && tgt_wdata == wd, "R11",
                  "write attributes", tgt_wdata, wd);
        end
        check(req_ready == 1'b0, "R10", "req_ready while busy", {31'b0, req_ready}, 32'h0);
        @(negedge clk);
        check(rsp_valid == 1'b1, "R10", "rsp_valid", {31'b0, rsp_valid}, 32'h1);
        check(rsp_rdata == erd, eerr ? "R9" : (tag == "R8" ? "R8" : "R10"), "rsp_rdata", rsp_rdata, erd);
        check(tgt_valid == 1'b0 && dec_err == 1'b0, "R1", "strobe single cycle",
              {30'b0, tgt_valid, dec_err}, 32'h0);
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            check(rsp_valid == 1'b1 && rsp_rdata == erd, "R10", "response held", rsp_rdata, erd);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        check(rsp_valid == 1'b0 && req_ready == 1'b1, "R10", "response taken",
              {30'b0, rsp_valid, req_ready}, 32'h1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        check(req_ready == 1'b1 && rsp_valid == 1'b0 && tgt_valid == 1'b0 && dec_err == 1'b0,
              "R12", "reset outputs", {28'b0, req_ready, rsp_valid, tgt_valid, dec_err}, 32'h8);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 every device lane plus the no-lane case
        for (int i = 0; i <= 11; i++) begin
            logic [31:0] a;
            a = 32'h8080_0000 | ((i * 37) & 32'h7FF);
            if (i < 11) a = a | (32'h1 << (11 + i));
            run(a, 1'b0, 3'd4, 32'h0, 1'b0, 0);
        end
        run(32'h8080_0000 | (32'h1 << 21) | (32'h1 << 14) | 32'h123, 1'b0, 3'd4, 0, 1'b0, 1);
        run(32'h80BF_FFFF, 1'b1, 3'd1, 32'h0000_00AB, 1'b0, 0);

        // R4 / R5 low I/O in both layouts, mode flipping between requests
        for (int m = 0; m < 2; m++) begin
            run(32'h8000_0000, 1'b0, 3'd1, 0, m[0], 0);
            run(32'h8000_001F, 1'b1, 3'd2, 32'h0000_BEEF, m[0], 0);
            run(32'h8000_0FE3, 1'b0, 3'd4, 0, m[0], 0);
            run(32'h8012_3456, 1'b0, 3'd2, 0, m[0], 0);
            run(32'h8001_0000, 1'b1, 3'd4, 32'hCAFE_F00D, m[0], 0);
            run(32'h807F_FFFF, 1'b0, 3'd1, 0, m[0], 0);
            run(32'h8055_5AAA, 1'b0, 3'd4, 0, ~m[0], 0);
        end

        // R3 plain I/O above the configuration window
        run(32'h80C0_0000, 1'b0, 3'd4, 0, 1'b1, 0);
        run(32'hBF7F_FFFF, 1'b1, 3'd1, 32'h11, 1'b0, 0);

        // R8 interrupt acknowledge
        run(32'hBFFF_FFF0, 1'b0, 3'd1, 0, 1'b0, 2);
        iack_vector = 8'hE7;
        run(32'hBFFF_FFF0, 1'b0, 3'd1, 0, 1'b0, 0);
        run(32'hBFFF_FFF0, 1'b1, 3'd1, 32'h55, 1'b0, 0);

        // R9 unmapped gaps and the non-byte interrupt-acknowledge access
        run(32'hBFFF_FFF0, 1'b0, 3'd2, 0, 1'b0, 0);
        run(32'hBFFF_FFEF, 1'b0, 3'd1, 0, 1'b0, 0);
        run(32'hBFFF_FFF1, 1'b0, 3'd1, 0, 1'b0, 1);
        run(32'hBF80_0000, 1'b0, 3'd4, 0, 1'b0, 0);
        run(32'h7FFF_FFFF, 1'b0, 3'd4, 0, 1'b0, 0);
        run(32'h0000_0000, 1'b1, 3'd4, 32'h1234_5678, 1'b0, 0);
        run(32'hFF00_0000, 1'b0, 3'd4, 0, 1'b0, 0);
        run(32'hFFEF_FFFF, 1'b0, 3'd1, 0, 1'b0, 0);

        // R6 memory and R7 boot ROM edges
        run(32'hC000_0000, 1'b0, 3'd4, 0, 1'b0, 0);
        run(32'hFEFF_FFFF, 1'b1, 3'd1, 32'h99, 1'b0, 0);
        run(32'hD234_5670, 1'b0, 3'd2, 0, 1'b0, 3);
        run(32'hFFF0_0000, 1'b0, 3'd4, 0, 1'b0, 0);
        run(32'hFFFF_FFFF, 1'b0, 3'd1, 0, 1'b0, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule